// File: doc/BRIEF.md
# NAND Flash Bad Block Scanner

This controller runs a complete read-only survey of an 8-bit asynchronous NAND flash device. It is started with a single pulse. It first issues an identification read and keeps the returned identification bytes. It then visits every block in ascending order. For each block it opens the first page with a two-phase page read, addressed at the first spare byte, waits until the device reports ready, and fetches that one byte. A block whose byte is anything other than FFh is a factory-marked bad block. Its number goes into a small list and a counter of bad blocks is incremented.

The controller never issues a program or erase command. An erase would wipe the factory mark, and that mark cannot be rebuilt afterwards. Block 0 gets no special treatment. The bidirectional data pins are split into an output byte, an output enable and an input byte, so the pad cell stays outside the block. Strobe low and high widths are set by parameters. A busy wait that exceeds a parameterised number of clocks ends the scan with an error flag.

Top module: `nbs_scan_ctrl`

## Requirements
- R1: When `start` is seen while the controller is idle, the first command cycle carries 90h and is followed by one address cycle of 00h. Then come ID_BYTES read strobes. Byte k of the reply lands in `id_bytes[8k+7:8k]`, so the first byte is in the lowest bits.
- R2: In a command cycle `nf_cmd_latch`=1 and `nf_addr_latch`=0. In an address cycle the two flags are swapped. The two flags are never high together. `nf_dq_oe` is high and `nf_dq_o` is stable while `nf_wr_n` is low, and the device takes the byte on the rising edge of `nf_wr_n`. `nf_chip_sel_n` is low during every strobe.
- R3: Blocks are visited from 0 to BLOCKS-1. Each visit is exactly six write cycles in this order: command 00h, address 00h, address 08h (column 0800h, low byte first), row low byte, row high byte, command 30h. The row is the block number shifted left by PAGE_BITS.
- R4: After the 30h command the controller waits SETTLE clocks. It then waits until `nf_ready` is high and issues exactly one read strobe to fetch the marker byte. No read strobe starts while `nf_ready` is low.
- R5: A marker other than FFh adds the block number to the list in scan order and increments `bad_count` by one. A marker of FFh changes neither. Block 0 is judged the same way. List slot i is read through `list_idx` / `list_block`, and slots not yet filled read 0.
- R6: `bad_count` keeps counting past LIST_DEPTH. The list keeps only the first LIST_DEPTH bad blocks.
- R7: Every `nf_wr_n` or `nf_rd_n` pulse stays low for at least T_LO clocks. The strobes stay high for at least T_HI clocks between pulses. The two strobes are never low together.
- R8: The only command bytes ever written are 90h, 00h and 30h. No erase (60h/D0h) or program command appears.
- R9: If `nf_ready` stays low for BUSY_TIMEOUT clocks after the settle wait, the scan stops. `timeout_err`=1, `done`=0, `busy`=0 and `nf_chip_sel_n`=1, and no further bus cycles follow.
- R10: After the last block, `done`=1, `busy`=0 and `nf_chip_sel_n`=1, and `bad_count` holds the final total. All of these hold until the next `start`, which clears `done`, `timeout_err`, `bad_count` and the list.
- R11: After reset: `nf_chip_sel_n`=1, both strobes high, both latch flags low, `nf_dq_oe`=0, `busy`=`done`=`timeout_err`=0, `bad_count`=0.
- R12: A `start` pulse during a scan is ignored, and the bus sequence carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a scan when idle |
| nf_chip_sel_n | output | 1 | Device select, active low |
| nf_cmd_latch | output | 1 | Marks a command cycle |
| nf_addr_latch | output | 1 | Marks an address cycle |
| nf_wr_n | output | 1 | Write strobe, data taken on its rising edge |
| nf_rd_n | output | 1 | Read strobe |
| nf_ready | input | 1 | Device ready (high) / busy (low) |
| nf_dq_o | output | 8 | Byte driven toward the device |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_o` |
| nf_dq_i | input | 8 | Byte returned by the device |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan completed over all blocks |
| timeout_err | output | 1 | Scan aborted on a busy timeout |
| bad_count | output | $clog2(BLOCKS+1) | Number of bad blocks found |
| id_bytes | output | 8*ID_BYTES | Identification bytes, first byte in low bits |
| list_idx | input | $clog2(LIST_DEPTH) | Bad list read index |
| list_block | output | $clog2(BLOCKS) | Block number in slot `list_idx` |

## Verification
Two situations are hard to reach from the ports. The first is a device that never leaves busy in the middle of a scan. The bench device model holds ready low forever after the 30h command of one chosen block. It then checks that the abort lands inside the timeout window, that nothing further appears on the bus, and that a following start recovers cleanly. The second is list overflow, which needs more bad blocks than list slots. A marker pattern with eleven bad blocks against eight slots covers it. A start pulse injected mid-scan is checked against the expected bus-cycle queue, which would reject any restart.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam logic [7:0] CMD_ID_READ   = 8'h90;
    localparam logic [7:0] CMD_PAGE_OPEN = 8'h00;
    localparam logic [7:0] CMD_PAGE_GO   = 8'h30;
    localparam logic [7:0] MARK_GOOD     = 8'hFF;
    localparam logic [15:0] COL_SPARE    = 16'h0800;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } strobe_ph_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID_CMD,
        ST_ID_ADR,
        ST_ID_RD,
        ST_PG_CMD,
        ST_PG_ADR,
        ST_PG_GO,
        ST_SETTLE,
        ST_WAIT_RB,
        ST_MARK_RD,
        ST_JUDGE
    } scan_st_e;

    function automatic logic is_bus_state(scan_st_e s);
        return (s == ST_ID_CMD) || (s == ST_ID_ADR) || (s == ST_ID_RD) ||
               (s == ST_PG_CMD) || (s == ST_PG_ADR) || (s == ST_PG_GO) ||
               (s == ST_MARK_RD);
    endfunction

    function automatic logic is_write_state(scan_st_e s);
        return (s == ST_ID_CMD) || (s == ST_ID_ADR) || (s == ST_PG_CMD) ||
               (s == ST_PG_ADR) || (s == ST_PG_GO);
    endfunction

endpackage

// File: rtl/nbs_strobe.sv
module nbs_strobe
    import nbs_pkg::*;
#(
    parameter int T_LO = 3,
    parameter int T_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rd_req,
    output logic wr_n,
    output logic rd_n,
    output logic sample,
    output logic fin
);

    localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        strobe_ph_e    ph;
        logic          rd;
        logic [CW-1:0] cnt;
        logic          wr_n;
        logic          rd_n;
    } stb_t;

    stb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (go) begin
                    s_d.ph  = PH_LOW;
                    s_d.rd  = rd_req;
                    s_d.cnt = '0;
                end
            end
            PH_LOW: begin
                if (s_q.cnt == CW'(T_LO - 1)) begin
                    s_d.ph  = PH_HIGH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (s_q.cnt == CW'(T_HI - 1)) begin
                    s_d.ph  = PH_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        s_d.wr_n = !((s_d.ph == PH_LOW) && !s_d.rd);
        s_d.rd_n = !((s_d.ph == PH_LOW) && s_d.rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, rd: 1'b0, cnt: '0, wr_n: 1'b1, rd_n: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_n   = s_q.wr_n;
    assign rd_n   = s_q.rd_n;
    assign sample = (s_q.ph == PH_LOW) && s_q.rd && (s_q.cnt == CW'(T_LO - 1));
    assign fin    = (s_q.ph == PH_HIGH) && (s_q.cnt == CW'(T_HI - 1));

    // run-length counters observed on the strobe pins
    logic [15:0] lo_run, hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= 16'hFFFF;
        end else if (!wr_n || !rd_n) begin
            lo_run <= (lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1;
            hi_run <= '0;
        end else begin
            hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1;
            lo_run <= '0;
        end
    end

    AST_STROBE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_n) || $rose(rd_n)) |-> (int'(lo_run) >= T_LO)); // R7
    AST_STROBE_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_n) || $fell(rd_n)) |-> (int'(hi_run) >= T_HI)); // R7
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (s_q.ph == PH_IDLE)); // R7

endmodule

// File: rtl/nbs_badlist.sv
module nbs_badlist #(
    parameter int DEPTH = 16,
    parameter int BW    = 10,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [BW-1:0] wdata,
    input  logic [IW-1:0] rd_idx,
    output logic [BW-1:0] rdata
);

    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] ent;
        logic [PW-1:0]            fill;
    } lst_t;

    lst_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (clr) begin
            l_d.ent  = '0;
            l_d.fill = '0;
        end else if (wr && (int'(l_q.fill) < DEPTH)) begin
            l_d.ent[IW'(l_q.fill)] = wdata;
            l_d.fill = l_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign rdata = (int'(rd_idx) < int'(l_q.fill)) ? l_q.ent[rd_idx] : '0;

    AST_LIST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(l_q.fill) <= DEPTH); // R6
    AST_LIST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && (int'(l_q.fill) == DEPTH)) |=> $stable(l_q.ent)); // R6

endmodule

// File: rtl/nbs_scan_ctrl.sv
module nbs_scan_ctrl
    import nbs_pkg::*;
#(
    parameter int BLOCKS       = 1024,
    parameter int PAGE_BITS    = 6,
    parameter int ID_BYTES     = 4,
    parameter int LIST_DEPTH   = 16,
    parameter int T_LO         = 3,
    parameter int T_HI         = 2,
    parameter int SETTLE       = 4,
    parameter int BUSY_TIMEOUT = 100000,
    localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
    localparam int CNT_W  = $clog2(BLOCKS + 1),
    localparam int LIST_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  nf_chip_sel_n,
    output logic                  nf_cmd_latch,
    output logic                  nf_addr_latch,
    output logic                  nf_wr_n,
    output logic                  nf_rd_n,
    input  logic                  nf_ready,
    output logic [7:0]            nf_dq_o,
    output logic                  nf_dq_oe,
    input  logic [7:0]            nf_dq_i,
    output logic                  busy,
    output logic                  done,
    output logic                  timeout_err,
    output logic [CNT_W-1:0]      bad_count,
    output logic [8*ID_BYTES-1:0] id_bytes,
    input  logic [LIST_W-1:0]     list_idx,
    output logic [BLK_W-1:0]      list_block
);

    localparam int IDX_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam int TMAX  = (SETTLE > BUSY_TIMEOUT) ? SETTLE : BUSY_TIMEOUT;
    localparam int TW    = $clog2(TMAX + 1);

    typedef struct packed {
        scan_st_e             st;
        logic                 launched;
        logic [1:0]           aidx;
        logic [BLK_W-1:0]     blk;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idcnt;
        logic [8*ID_BYTES-1:0] idreg;
        logic [7:0]           mark;
        logic [TW-1:0]        tmr;
        logic                 done;
        logic                 err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic go, rd_req, sample, fin, cyc_end;
    logic list_clr, list_wr;
    logic [15:0] row;

    assign rd_req  = (c_q.st == ST_ID_RD) || (c_q.st == ST_MARK_RD);
    assign cyc_end = c_q.launched && fin;
    assign row     = 16'(c_q.blk) << PAGE_BITS;

    always_comb begin
        c_d      = c_q;
        go       = 1'b0;
        list_clr = 1'b0;
        list_wr  = 1'b0;

        if (is_bus_state(c_q.st)) begin
            if (!c_q.launched) begin
                go         = 1'b1;
                c_d.launched = 1'b1;
            end else if (fin) begin
                c_d.launched = 1'b0;
            end
        end

        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st       = ST_ID_CMD;
                    c_d.launched = 1'b0;
                    c_d.cnt      = '0;
                    c_d.idreg    = '0;
                    c_d.idcnt    = '0;
                    c_d.blk      = '0;
                    c_d.done     = 1'b0;
                    c_d.err      = 1'b0;
                    list_clr     = 1'b1;
                end
            end
            ST_ID_CMD: if (cyc_end) c_d.st = ST_ID_ADR;
            ST_ID_ADR: begin
                if (cyc_end) begin
                    c_d.st    = ST_ID_RD;
                    c_d.idcnt = '0;
                end
            end
            ST_ID_RD: begin
                if (sample) c_d.idreg[int'(c_q.idcnt)*8 +: 8] = nf_dq_i;
                if (cyc_end) begin
                    if (c_q.idcnt == IDX_W'(ID_BYTES - 1)) begin
                        c_d.st    = ST_PG_CMD;
                        c_d.idcnt = '0;
                    end else begin
                        c_d.idcnt = c_q.idcnt + 1'b1;
                    end
                end
            end
            ST_PG_CMD: begin
                if (cyc_end) begin
                    c_d.st   = ST_PG_ADR;
                    c_d.aidx = '0;
                end
            end
            ST_PG_ADR: begin
                if (cyc_end) begin
                    if (c_q.aidx == 2'd3) c_d.st = ST_PG_GO;
                    else c_d.aidx = c_q.aidx + 1'b1;
                end
            end
            ST_PG_GO: begin
                if (cyc_end) begin
                    c_d.st  = ST_SETTLE;
                    c_d.tmr = '0;
                end
            end
            ST_SETTLE: begin
                if (c_q.tmr == TW'(SETTLE - 1)) begin
                    c_d.st  = ST_WAIT_RB;
                    c_d.tmr = '0;
                end else begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            ST_WAIT_RB: begin
                if (nf_ready) begin
                    c_d.st = ST_MARK_RD;
                end else if (c_q.tmr == TW'(BUSY_TIMEOUT - 1)) begin
                    c_d.st  = ST_IDLE;
                    c_d.err = 1'b1;
                end else begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            ST_MARK_RD: begin
                if (sample) c_d.mark = nf_dq_i;
                if (cyc_end) c_d.st = ST_JUDGE;
            end
            ST_JUDGE: begin
                if (c_q.mark != MARK_GOOD) begin
                    list_wr = 1'b1;
                    c_d.cnt = c_q.cnt + 1'b1;
                end
                if (c_q.blk == BLK_W'(BLOCKS - 1)) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else begin
                    c_d.blk = c_q.blk + 1'b1;
                    c_d.st  = ST_PG_CMD;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, launched: 1'b0, aidx: '0, blk: '0, cnt: '0,
                     idcnt: '0, idreg: '0, mark: '0, tmr: '0, done: 1'b0, err: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    // byte placed on the bus for each write state
    always_comb begin
        case (c_q.st)
            ST_ID_CMD: nf_dq_o = CMD_ID_READ;
            ST_ID_ADR: nf_dq_o = 8'h00;
            ST_PG_CMD: nf_dq_o = CMD_PAGE_OPEN;
            ST_PG_GO:  nf_dq_o = CMD_PAGE_GO;
            ST_PG_ADR: begin
                case (c_q.aidx)
                    2'd0:    nf_dq_o = COL_SPARE[7:0];
                    2'd1:    nf_dq_o = COL_SPARE[15:8];
                    2'd2:    nf_dq_o = row[7:0];
                    default: nf_dq_o = row[15:8];
                endcase
            end
            default:   nf_dq_o = 8'h00;
        endcase
    end

    nbs_strobe #(
        .T_LO (T_LO),
        .T_HI (T_HI)
    ) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .rd_req (rd_req),
        .wr_n   (nf_wr_n),
        .rd_n   (nf_rd_n),
        .sample (sample),
        .fin    (fin)
    );

    nbs_badlist #(
        .DEPTH (LIST_DEPTH),
        .BW    (BLK_W)
    ) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (list_clr),
        .wr     (list_wr),
        .wdata  (c_q.blk),
        .rd_idx (list_idx),
        .rdata  (list_block)
    );

    assign nf_chip_sel_n = (c_q.st == ST_IDLE);
    assign nf_cmd_latch  = (c_q.st == ST_ID_CMD) || (c_q.st == ST_PG_CMD) || (c_q.st == ST_PG_GO);
    assign nf_addr_latch = (c_q.st == ST_ID_ADR) || (c_q.st == ST_PG_ADR);
    assign nf_dq_oe      = is_write_state(c_q.st);
    assign busy          = (c_q.st != ST_IDLE);
    assign done          = c_q.done;
    assign timeout_err   = c_q.err;
    assign bad_count     = c_q.cnt;
    assign id_bytes      = c_q.idreg;

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cmd_latch && nf_addr_latch)); // R2
    AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_wr_n |-> (nf_dq_oe && !nf_chip_sel_n)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_wr_n && !nf_rd_n)); // R7
    AST_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nf_wr_n) && nf_cmd_latch) |->
        ((nf_dq_o == CMD_ID_READ) || (nf_dq_o == CMD_PAGE_OPEN) || (nf_dq_o == CMD_PAGE_GO))); // R8
    AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nf_rd_n) |-> nf_ready); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |-> (nf_chip_sel_n && !busy)); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bad_count) <= BLOCKS); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((bad_count == $past(bad_count)) ||
                  (bad_count == CNT_W'($past(bad_count) + 1'b1)))); // R5

endmodule

// File: tb/nbs_scan_ctrl_test.sv
module nbs_scan_ctrl_test;

    localparam int BLK = 16;
    localparam int PB  = 6;
    localparam int IDN = 4;
    localparam int DEP = 8;
    localparam int TLO = 2;
    localparam int THI = 2;
    localparam int SET = 3;
    localparam int TO  = 200;
    localparam int CW  = $clog2(BLK + 1);
    localparam int BW  = $clog2(BLK);
    localparam int IW  = $clog2(DEP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready = 1'b1;
    logic [7:0] dq_i = 8'h00;
    logic [IW-1:0] list_idx = '0;

    logic ce_n, cle, ale, wr_n, rd_n, dq_oe, busy, done, terr;
    logic [7:0] dq_o;
    logic [CW-1:0] bad_count;
    logic [8*IDN-1:0] id_bytes;
    logic [BW-1:0] list_block;

    always #10 clk = ~clk;

    nbs_scan_ctrl #(
        .BLOCKS(BLK), .PAGE_BITS(PB), .ID_BYTES(IDN), .LIST_DEPTH(DEP),
        .T_LO(TLO), .T_HI(THI), .SETTLE(SET), .BUSY_TIMEOUT(TO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .nf_chip_sel_n(ce_n), .nf_cmd_latch(cle), .nf_addr_latch(ale),
        .nf_wr_n(wr_n), .nf_rd_n(rd_n), .nf_ready(ready),
        .nf_dq_o(dq_o), .nf_dq_oe(dq_oe), .nf_dq_i(dq_i),
        .busy(busy), .done(done), .timeout_err(terr),
        .bad_count(bad_count), .id_bytes(id_bytes),
        .list_idx(list_idx), .list_block(list_block)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // device model state
    logic [7:0] marks [BLK];
    logic [7:0] idv [IDN] = '{8'hA7, 8'h3C, 8'h51, 8'h95};
    int stuck_blk = -1;
    int busy_len  = 12;
    int mode = 0, ptr = 0, acnt = 0, busy_cnt = 0, cur_blk = 0, rd_pulses = 0;
    logic [15:0] row = '0;
    logic [9:0] exp_q [$];
    longint cyc = 0, t30 = 0;
    bit prev_wr = 1'b1, prev_rd = 1'b1;
    int lo = 0, hi = 1000;

    always @(negedge clk) begin
        logic [9:0] got, e;
        cyc++;
        if (!rst_n) begin
            ready = 1'b1;
        end else begin
            if (!wr_n || !rd_n) begin
                if (prev_wr && prev_rd) begin
                    chk(hi >= THI, "R7 strobe high time", hi, THI);
                    chk(!ce_n, "R2 select low at strobe", ce_n, 0);
                    chk(!(!wr_n && !rd_n), "R7 strobes exclusive", {wr_n, rd_n}, 2'b01);
                    hi = 0;
                end
                lo++;
            end else begin
                if (!prev_wr || !prev_rd) begin
                    chk(lo >= TLO, "R7 strobe low time", lo, TLO);
                    lo = 0;
                end
                hi++;
            end
            if (!prev_wr && wr_n) begin
                got = {cle, ale, dq_o};
                chk(dq_oe && !(cle && ale), "R2 write cycle flags", {dq_oe, cle, ale}, 3'b1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected bus cycle", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e, (cle && dq_o == 8'h90) ? "R1 id cycle" : "R3 bus cycle", got, e);
                end
                if (cle) begin
                    chk(dq_o == 8'h90 || dq_o == 8'h00 || dq_o == 8'h30, "R8 command set", dq_o, 8'h00);
                    if (dq_o == 8'h90) begin mode = 1; ptr = 0; ready = 1'b1; end
                    else if (dq_o == 8'h00) begin mode = 2; acnt = 0; end
                    else if (dq_o == 8'h30) begin
                        cur_blk = int'(row >> PB);
                        ready = 1'b0;
                        busy_cnt = busy_len;
                        t30 = cyc;
                    end
                end
                if (ale && mode == 2) begin
                    if (acnt == 2) row[7:0] = dq_o;
                    if (acnt == 3) row[15:8] = dq_o;
                    acnt++;
                end
            end
            if (prev_rd && !rd_n) begin
                chk(ready, "R4 read only when ready", ready, 1);
                dq_i = (mode == 1) ? idv[ptr % IDN] : marks[cur_blk % BLK];
            end
            if (!prev_rd && rd_n) begin
                ptr++;
                rd_pulses++;
            end
            if (!ready && cur_blk != stuck_blk) begin
                if (busy_cnt > 0) busy_cnt--;
                else ready = 1'b1;
            end
        end
        prev_wr = wr_n;
        prev_rd = rd_n;
    end

    task automatic build(input int upto);
        exp_q.delete();
        exp_q.push_back({2'b10, 8'h90});
        exp_q.push_back({2'b01, 8'h00});
        for (int b = 0; b <= upto; b++) begin
            logic [15:0] r;
            r = 16'(b) << PB;
            exp_q.push_back({2'b10, 8'h00});
            exp_q.push_back({2'b01, 8'h00});
            exp_q.push_back({2'b01, 8'h08});
            exp_q.push_back({2'b01, r[7:0]});
            exp_q.push_back({2'b01, r[15:8]});
            exp_q.push_back({2'b10, 8'h30});
        end
    endtask

    task automatic run_scan(input int mid_start);
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!(done || terr) && n < 20000) begin
            @(negedge clk);
            n++;
            if (n == mid_start) begin
                start = 1'b1;
                @(negedge clk) start = 1'b0;
                chk(busy, "R12 start during scan ignored", busy, 1);
            end
        end
    endtask

    task automatic check_list(input string tag);
        int nbad;
        int exp_l [DEP];
        nbad = 0;
        for (int i = 0; i < DEP; i++) exp_l[i] = 0;
        for (int b = 0; b < BLK; b++) begin
            if (marks[b] != 8'hFF) begin
                if (nbad < DEP) exp_l[nbad] = b;
                nbad++;
            end
        end
        chk(int'(bad_count) == nbad, {tag, " bad count"}, bad_count, nbad);
        for (int i = 0; i < DEP; i++) begin
            list_idx = IW'(i);
            #1;
            chk(int'(list_block) == exp_l[i], {tag, " list slot"}, list_block, exp_l[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int b = 0; b < BLK; b++) marks[b] = 8'hFF;
        repeat (4) @(negedge clk);
        chk(ce_n && wr_n && rd_n && !cle && !ale && !dq_oe, "R11 bus idle in reset",
            {ce_n, wr_n, rd_n, cle, ale, dq_oe}, 6'b111000);
        chk(!busy && !done && !terr && bad_count == 0, "R11 status in reset",
            {busy, done, terr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // scan with three bad blocks, block 0 among them, and a stray start
        marks[0] = 8'h00; marks[5] = 8'h0F; marks[13] = 8'hFE;
        build(BLK - 1);
        rd_pulses = 0;
        run_scan(150);
        chk(done && !busy && ce_n, "R10 done state", {done, busy, ce_n}, 3'b101);
        chk(id_bytes == {idv[3], idv[2], idv[1], idv[0]}, "R1 id bytes", id_bytes,
            {idv[3], idv[2], idv[1], idv[0]});
        chk(exp_q.size() == 0, "R3 all blocks visited", exp_q.size(), 0);
        chk(rd_pulses == IDN + BLK, "R4 one marker read per block", rd_pulses, IDN + BLK);
        check_list("R5");
        repeat (10) @(negedge clk);
        chk(done && int'(bad_count) == 3, "R10 result held", {done, bad_count}, 3);

        // more bad blocks than list slots
        for (int b = 0; b < BLK; b++) marks[b] = 8'hFF;
        for (int b = 1; b <= 11; b++) marks[b] = (b % 2 == 0) ? 8'h7F : 8'h00;
        build(BLK - 1);
        run_scan(-1);
        chk(done, "R6 scan completes", done, 1);
        check_list("R6");

        // device stuck busy on block 2
        for (int b = 0; b < BLK; b++) marks[b] = 8'hFF;
        stuck_blk = 2;
        build(2);
        run_scan(-1);
        chk(terr && !done && !busy && ce_n, "R9 abort state", {terr, done, busy, ce_n}, 4'b1001);
        chk((cyc - t30) >= TO && (cyc - t30) <= TO + SET + THI + 6, "R9 timeout window",
            cyc - t30, TO);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0 && ce_n, "R9 no cycles after abort", exp_q.size(), 0);

        // restart after error, all blocks good
        stuck_blk = -1;
        build(BLK - 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!terr && !done && int'(bad_count) == 0, "R10 start clears status",
            {terr, done, bad_count}, 0);
        begin
            int n;
            n = 0;
            while (!(done || terr) && n < 20000) begin
                @(negedge clk);
                n++;
            end
        end
        chk(done && !terr, "R10 clean rescan", {done, terr}, 2'b10);
        check_list("R5 all good");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule